// File: doc/BRIEF.md
# Impulse-Response Coefficient Auto-Scaler

This block sits between the loader of a channel impulse-response profile and the tap coefficient registers of a filter. It takes one signed coefficient per cycle and finds the largest magnitude in the profile. From that peak it picks a power-of-two gain `k` that lifts the peak into the upper half of full scale. It then replays the stored coefficients, each shifted left by `k`.

The gain has to be undone after the filter. The block therefore also produces one 14-bit scale word for an external programmable analog amplifier. That word folds together the gain `k` and the shift applied by the later sliding-window output truncation. Its top bit gives the direction: 1 means the amplifier multiplies, 0 means it divides.

The scaling is done on the coefficients and never on the fast input samples. Samples cannot be known ahead of time, but a whole profile is known before it is used.

Top module: `asf_scaler`

## Requirements
- R1: After reset, `out_valid`, `out_first`, `out_last` and `scale_done` are 0, and `scale_word` and `out_coef` are 0.
- R2: The peak is the largest absolute value among the stored coefficients. The code -2^(CW-1) counts as magnitude 2^(CW-1)-1.
- R3: If the peak is at least 2^(CW-2) (half of full scale), then k = 0 and every coefficient is replayed unchanged.
- R4: If the peak is nonzero and below 2^(CW-2), k is the number of left shifts that places peak·2^k in [2^(CW-2), 2^(CW-1)). Each replayed coefficient equals its input value times 2^k.
- R5: A profile whose coefficients are all zero gives k = 0 and replays zeros.
- R6: The value `in_tshift` present with the last coefficient is the truncation shift t. Let n = k - t. `scale_word[13]` is 1 when n >= 0 and 0 when n < 0. `scale_word[12:0]` holds |n|.
- R7: `scale_done` is a one-cycle pulse in the cycle after the last coefficient is accepted. `scale_word` takes its new value in that same cycle and then holds it until the next pulse.
- R8: Replay starts in the cycle after `scale_done`. It produces one coefficient per cycle, in input order, with one output per accepted coefficient. `out_first` marks the first output and `out_last` the final one, and `out_valid` drops right after the final one.
- R9: A coefficient presented with `in_valid` during replay is ignored. It changes neither the replayed values nor `scale_word`, and it raises no `scale_done`.
- R10: `in_first` starts a new profile. A coefficient that has `in_first` and `in_last` together forms a one-entry profile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Coefficient present this cycle |
| in_first | input | 1 | Coefficient opens a profile |
| in_last | input | 1 | Coefficient closes a profile |
| in_coef | input | CW (16) | Signed coefficient |
| in_tshift | input | TW (3) | Output truncation shift, sampled with the last coefficient |
| out_valid | output | 1 | Scaled coefficient present |
| out_first | output | 1 | First scaled coefficient of the profile |
| out_last | output | 1 | Final scaled coefficient of the profile |
| out_coef | output | CW (16) | Signed scaled coefficient |
| scale_done | output | 1 | Scale word updated this cycle |
| scale_word | output | SW (14) | Direction bit and magnitude of the net exponent |

## Verification
The bench targets the edges of the gain choice:
- A peak of exactly half scale and a peak one code below it: a comparison off by one would give the wrong k and would either overflow or leave a needless factor of two.
- The most negative code: without saturation its magnitude would wrap and yield a large bogus gain.
- An all-zero profile: a naive leading-zero search would return the maximum shift.
- Truncation shifts equal to k and larger than k: a design that mishandled the sign of k - t would set the wrong direction bit or a wrapped magnitude.
- Coefficients driven during replay: a design that accepted them would corrupt the replay or fire a spurious `scale_done`.

// File: rtl/asf_pkg.sv
package asf_pkg;

  typedef enum logic {ST_LOAD, ST_PLAY} asf_state_e;

  // Absolute value of a cw-bit signed code, most negative code clamped.
  function automatic int unsigned mag_sat(int signed v, int unsigned cw);
    int unsigned top;
    int unsigned m;
    top = (32'd1 << (cw - 1)) - 32'd1;
    m   = (v < 0) ? int'(-v) : int'(v);
    return (m > top) ? top : m;
  endfunction

  // Left shift count that lifts a nonzero peak below half scale to >= half.
  function automatic int unsigned gain_exp(int unsigned m, int unsigned cw);
    int unsigned half;
    int unsigned e;
    half = 32'd1 << (cw - 2);
    e = 0;
    if (m != 0 && m < half) begin
      for (int i = 0; i < 32; i++) begin
        if ((m << e) < half) e = e + 1;
      end
    end
    return e;
  endfunction

  // Direction bit on top, magnitude of the net exponent below it.
  function automatic int unsigned pack_word(int signed net, int unsigned sw);
    int unsigned dir;
    int unsigned mag;
    dir = (net >= 0) ? 32'd1 : 32'd0;
    mag = (net >= 0) ? int'(net) : int'(-net);
    return (dir << (sw - 1)) | mag;
  endfunction

endpackage

// File: rtl/asf_peak_tracker.sv
module asf_peak_tracker
  import asf_pkg::*;
#(
  parameter int CW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc,
  input  logic                 first,
  input  logic signed [CW-1:0] coef,
  output logic [CW-1:0]        peak_q,
  output logic [CW-1:0]        peak_nxt,
  output logic [CNTW-1:0]      cnt_q,
  output logic [CNTW-1:0]      cnt_nxt,
  output logic                 wr_en,
  output logic [AW-1:0]        wr_addr
);

  logic [CW-1:0] mag;
  logic          room;

  always_comb begin
    mag  = CW'(mag_sat(int'(coef), CW));
    room = first || (cnt_q < CNTW'(DEPTH));
    if (first)      peak_nxt = mag;
    else if (!room) peak_nxt = peak_q;
    else            peak_nxt = (mag > peak_q) ? mag : peak_q;
    if (first)      cnt_nxt = CNTW'(1);
    else if (room)  cnt_nxt = cnt_q + CNTW'(1);
    else            cnt_nxt = cnt_q;
    wr_en   = acc && room;
    wr_addr = first ? '0 : AW'(cnt_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      peak_q <= '0;
      cnt_q  <= '0;
    end else if (acc) begin
      peak_q <= peak_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  // R2: within a profile the running peak never falls
  p_peak_mono_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !first) |=> (peak_q >= $past(peak_q)));

endmodule

// File: rtl/asf_coef_store.sv
module asf_coef_store #(
  parameter int CW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [CW-1:0] wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic signed [CW-1:0] rd_data
);

  logic signed [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/asf_scale_encoder.sv
module asf_scale_encoder
  import asf_pkg::*;
#(
  parameter int CW = 16,
  parameter int TW = 3,
  parameter int SW = 14,
  localparam int KW = $clog2(CW)
) (
  input  logic [CW-1:0] peak,
  input  logic [TW-1:0] tshift,
  output logic [KW-1:0] k,
  output logic [SW-1:0] word
);

  int unsigned ke;
  int signed   net;

  always_comb begin
    ke   = gain_exp(32'(peak), CW);
    net  = int'(ke) - int'(32'(tshift));
    k    = KW'(ke);
    word = SW'(pack_word(net, SW));
  end

endmodule

// File: rtl/asf_scaler.sv
module asf_scaler
  import asf_pkg::*;
#(
  parameter int CW    = 16,
  parameter int DEPTH = 32,
  parameter int TW    = 3,
  parameter int SW    = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_first,
  input  logic                 in_last,
  input  logic signed [CW-1:0] in_coef,
  input  logic [TW-1:0]        in_tshift,
  output logic                 out_valid,
  output logic                 out_first,
  output logic                 out_last,
  output logic signed [CW-1:0] out_coef,
  output logic                 scale_done,
  output logic [SW-1:0]        scale_word
);

  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int KW   = $clog2(CW);
  localparam logic [CW:0] HALF_W = (CW+1)'(1) << (CW - 2);
  localparam logic [CW:0] FULL_W = (CW+1)'(1) << (CW - 1);

  asf_state_e           state;
  logic                 acc, finish, is_end;
  logic [CW-1:0]        peak_q, peak_nxt;
  logic [CNTW-1:0]      cnt_q, cnt_nxt, len_q;
  logic                 wr_en;
  logic [AW-1:0]        wr_addr, rd_ptr;
  logic signed [CW-1:0] rd_data;
  logic [KW-1:0]        k_nxt, k_q;
  logic [SW-1:0]        word_nxt, word_q;
  logic [CW:0]          peak_shifted;

  assign acc    = in_valid && (state == ST_LOAD);
  assign finish = acc && in_last;
  assign is_end = (CNTW'(rd_ptr) + CNTW'(1)) == len_q;

  asf_peak_tracker #(.CW(CW), .DEPTH(DEPTH)) u_track (
    .clk(clk), .rst_n(rst_n), .acc(acc), .first(in_first), .coef(in_coef),
    .peak_q(peak_q), .peak_nxt(peak_nxt), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
    .wr_en(wr_en), .wr_addr(wr_addr)
  );

  asf_coef_store #(.CW(CW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_coef),
    .rd_addr(rd_ptr), .rd_data(rd_data)
  );

  asf_scale_encoder #(.CW(CW), .TW(TW), .SW(SW)) u_enc (
    .peak(peak_nxt), .tshift(in_tshift), .k(k_nxt), .word(word_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_LOAD;
      k_q        <= '0;
      word_q     <= '0;
      len_q      <= '0;
      rd_ptr     <= '0;
      scale_done <= 1'b0;
      out_valid  <= 1'b0;
      out_first  <= 1'b0;
      out_last   <= 1'b0;
      out_coef   <= '0;
    end else begin
      scale_done <= finish;
      out_valid  <= 1'b0;
      out_first  <= 1'b0;
      out_last   <= 1'b0;
      if (finish) begin
        k_q    <= k_nxt;
        word_q <= word_nxt;
        len_q  <= cnt_nxt;
        rd_ptr <= '0;
        state  <= ST_PLAY;
      end
      if (state == ST_PLAY) begin
        out_valid <= 1'b1;
        out_coef  <= rd_data <<< k_q;
        out_first <= (rd_ptr == '0);
        out_last  <= is_end;
        if (is_end) state  <= ST_LOAD;
        else        rd_ptr <= rd_ptr + AW'(1);
      end
    end
  end

  assign scale_word   = word_q;
  assign peak_shifted = {1'b0, peak_q} << k_q;

  // R7: the update strobe lasts a single cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scale_done |=> !scale_done);

  // R3: a peak already in the upper half receives no gain
  p_no_gain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_done && ({1'b0, peak_q} >= HALF_W)) |-> (k_q == '0));

  // R4: the chosen gain lands the peak in the upper half without overflow
  p_peak_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_done && peak_q != '0 && ({1'b0, peak_q} < HALF_W)) |->
      (peak_shifted >= HALF_W && peak_shifted < FULL_W));

  // R5: an all-zero profile leaves the gain at unity
  p_zero_unity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_done && peak_q == '0) |-> (k_q == '0));

  // R6: direction bit follows the sign of gain minus truncation shift
  p_word_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scale_done |-> (scale_word[SW-1] == (32'(k_q) >= 32'($past(in_tshift)))));

  // R8: replay never begins without a preceding update strobe
  p_play_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(scale_done));

  // R9: coefficients offered during replay leave the stored count alone
  p_ignore_play_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PLAY && in_valid) |=> $stable(cnt_q));

endmodule

// File: tb/asf_scaler_bench.sv
module asf_scaler_bench;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid, in_first, in_last;
  logic signed [15:0] in_coef;
  logic [2:0]         in_tshift;
  logic               out_valid, out_first, out_last;
  logic signed [15:0] out_coef;
  logic               scale_done;
  logic [13:0]        scale_word;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int prof [32];

  always #4 clk = ~clk;

  asf_scaler u_asf_scaler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_coef(in_coef), .in_tshift(in_tshift),
    .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
    .out_coef(out_coef), .scale_done(scale_done), .scale_word(scale_word)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_gain(input int pk);
    int g = 0;
    if (pk != 0) while ((pk * (1 << g)) < 16384) g++;
    return g;
  endfunction

  function automatic int ref_word(input int g, input int t);
    int d = g - t;
    return (d >= 0) ? (8192 + d) : -d;
  endfunction

  task automatic idle_inputs();
    in_valid = 0; in_first = 0; in_last = 0; in_coef = 0; in_tshift = 0;
  endtask

  // Loads prof[0..n-1], then checks the strobe, the word and the replay.
  task automatic run_profile(input int n, input int t, input bit junk, input string req);
    int pk = 0;
    int g, w;
    for (int i = 0; i < n; i++) begin
      int a = (prof[i] < 0) ? -prof[i] : prof[i];
      if (a > 32767) a = 32767;
      if (a > pk) pk = a;
    end
    g = ref_gain(pk);
    w = ref_word(g, t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_first = (i == 0); in_last = (i == n - 1);
      in_coef = 16'(prof[i]); in_tshift = 3'(t);
    end
    @(negedge clk);
    idle_inputs();
    chk(scale_done == 1'b1, "R7", {req, " strobe"}, int'(scale_done), 1);
    chk(int'(scale_word) == w, "R6", {req, " word"}, int'(scale_word), w);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R8", {req, " valid"}, int'(out_valid), 1);
      chk(int'(out_coef) == prof[j] * (1 << g), req, "scaled coef",
          int'(out_coef), prof[j] * (1 << g));
      chk(out_first == (j == 0), "R8", "first flag", int'(out_first), int'(j == 0));
      chk(out_last == (j == n - 1), "R8", "last flag", int'(out_last), int'(j == n - 1));
      if (j == 0) chk(scale_done == 1'b0, "R7", "strobe width", int'(scale_done), 0);
      if (junk && j < n - 1) begin
        in_valid = 1; in_first = 1; in_last = 1; in_coef = 16'sd123; in_tshift = 3'd5;
      end else begin
        idle_inputs();
      end
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", {req, " end of replay"}, int'(out_valid), 0);
    chk(int'(scale_word) == w, "R7", "word held", int'(scale_word), w);
  endtask

  task automatic t_reset();
    chk(out_valid == 0 && out_first == 0 && out_last == 0, "R1", "flags", int'(out_valid), 0);
    chk(scale_done == 0, "R1", "strobe", int'(scale_done), 0);
    chk(scale_word == 0, "R1", "word", int'(scale_word), 0);
    chk(out_coef == 0, "R1", "coef", int'(out_coef), 0);
  endtask

  task automatic t_small_peak();  // R2 R4: peak 300 gives k=6
    prof[0] = 100; prof[1] = -300; prof[2] = 50; prof[3] = 0;
    run_profile(4, 0, 0, "R4");
  endtask

  task automatic t_half_scale();  // R3: peak exactly half scale
    prof[0] = 16384; prof[1] = -5; prof[2] = 77;
    run_profile(3, 0, 0, "R3");
  endtask

  task automatic t_most_negative();  // R2: clamp of the most negative code
    prof[0] = -32768; prof[1] = 10;
    run_profile(2, 0, 0, "R2");
  endtask

  task automatic t_all_zero();
    prof[0] = 0; prof[1] = 0; prof[2] = 0;
    run_profile(3, 2, 0, "R5");
  endtask

  task automatic t_divide();  // R6: truncation shift beyond the gain
    prof[0] = 1000; prof[1] = -20;
    run_profile(2, 7, 0, "R6");
  endtask

  task automatic t_single_equal();  // R10 one entry; R6 net zero
    prof[0] = 4000;
    run_profile(1, 3, 0, "R10");
  endtask

  task automatic t_just_below();  // R4: peak one code under half
    prof[0] = -8191; prof[1] = 16383;
    run_profile(2, 1, 0, "R4");
  endtask

  task automatic t_full_depth();  // R8: every slot of the buffer
    for (int i = 0; i < 32; i++) prof[i] = i * 3 - 40;
    run_profile(32, 0, 0, "R8");
  endtask

  task automatic t_ignore_during_play();  // R9
    int w;
    prof[0] = -300; prof[1] = 5; prof[2] = 1200;
    run_profile(3, 0, 1, "R9");
    w = int'(scale_word);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(scale_done == 1'b0, "R9", "no stray strobe", int'(scale_done), 0);
      chk(out_valid == 1'b0, "R9", "no stray replay", int'(out_valid), 0);
      chk(int'(scale_word) == w, "R9", "word unchanged", int'(scale_word), w);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_small_peak();
    t_half_scale();
    t_most_negative();
    t_all_zero();
    t_divide();
    t_single_equal();
    t_just_below();
    t_full_depth();
    t_ignore_during_play();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule